// File: doc/BRIEF.md
# Dual-Standard CRC Engine

This block computes cyclic redundancy checks on behalf of a processor. It sits on a simple register bus with no wait states. Word address 0 holds the configuration and word address 1 is the data port. A configuration write picks the generator polynomial, either the 16-bit CCITT form or the 32-bit Ethernet form. It also picks how data and result bits are ordered, whether the result is inverted, and whether the seed is all-ones or all-zeros. The same write discards any previous remainder and loads the seed.

Each write to the data port absorbs up to four bytes into the remainder in the cycle it occurs. Byte enables choose which lanes take part, so a message of any length can be fed. Enabled lanes are taken from the most significant lane downwards. A read of the data port returns the shaped result at once. A read of the configuration port returns the stored fields.

A small two-state controller tracks whether the remainder still holds the seed. ST_SEEDED is entered at reset and on every configuration write (transition T_RELOAD). ST_FOLDING is entered when a data write carries at least one enabled lane (transition T_ABSORB). A data write with no enabled lane keeps the present state (transition T_HOLD).

Top module: `crc_engine`

## Requirements
- R1: With configuration bit 0 clear, the engine uses the 32-bit polynomial 0x04C11DB7 (x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1). For the nine ASCII bytes "123456789" it yields 0xCBF43926 with configuration 0x0E, 0x0376E6E7 with 0x00, 0xFC891918 with 0x08, and 0x340BC6D9 with 0x06.
- R2: With configuration bit 0 set, the engine uses the 16-bit polynomial 0x1021 (x^16+x^12+x^5+1). For "123456789" it yields 0x29B1 with configuration 0x01, 0x906E with 0x0F, 0x31C3 with 0x11, and 0x2189 with 0x17.
- R3: A write to address 0 stores wdata[4:0] as the configuration and loads the seed, discarding any partial remainder. The seed is all-ones across the selected width when bit 4 is clear, and zero when bit 4 is set.
- R4: A write to address 1 folds each enabled byte lane into the remainder in the same cycle, from lane 3 (wdata[31:24]) down to lane 0. Writes on consecutive cycles are all absorbed, and the new result is readable in the cycle after the write.
- R5: Lanes whose byte enable is low are skipped. A data write with all enables low leaves the result unchanged. Writes to addresses other than 0 and 1 change nothing.
- R6: Configuration bit 1 feeds each data byte least significant bit first; when it is clear, each byte is fed most significant bit first.
- R7: Configuration bit 2 reverses the result bit order across the selected width (16 or 32 bits).
- R8: Configuration bit 3 inverts every result bit across the selected width.
- R9: A read of address 1 returns the result with bits 31:16 zero in 16-bit mode. A read of address 0 returns the configuration in bits 4:0 and zeros above. Reads are combinational, and rdata is zero when no read is selected.
- R10: After reset the configuration is 0 (32-bit, no reflection, no inversion, all-ones seed) and the result reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address: 0 configuration, 1 data port |
| bus_be | input | 4 | Byte lane enables for data-port writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |

## Verification
A write is captured at the rising edge that ends its bus cycle. The configuration, seed and remainder it affects are visible on a read in the very next cycle, because reads are combinational and have no latency of their own. The bench drives each access on a falling edge and places reads one cycle after the last write. It samples rdata a nanosecond after raising the read strobe, still before the next rising edge. Back-to-back data writes are issued on successive cycles with no gaps, so every check of a folded message also confirms single-cycle absorption.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int CFG_W  = 5;

    localparam logic [31:0] POLY_WIDE   = 32'h04C11DB7;
    localparam logic [15:0] POLY_NARROW = 16'h1021;

    // bit 4 .. bit 0
    typedef struct packed {
        logic seed_zero;
        logic invert;
        logic refl_out;
        logic refl_in;
        logic narrow;
    } crc_cfg_t;

    typedef enum logic [0:0] {
        ST_SEEDED  = 1'b0,
        ST_FOLDING = 1'b1
    } crc_state_e;

    function automatic logic [31:0] seed_for(input crc_cfg_t c);
        logic [31:0] s;
        if (c.seed_zero) s = 32'h0;
        else if (c.narrow) s = 32'h0000FFFF;
        else s = 32'hFFFFFFFF;
        return s;
    endfunction

    // Shift one byte through the bitwise LFSR.
    function automatic logic [31:0] fold_byte(input logic [31:0] rem,
                                              input logic [7:0]  d,
                                              input crc_cfg_t    c);
        logic [31:0] r;
        logic [7:0]  x;
        logic        fb;
        r = rem;
        for (int k = 0; k < 8; k++) x[k] = c.refl_in ? d[7-k] : d[k];
        for (int i = 7; i >= 0; i--) begin
            if (c.narrow) begin
                fb = r[15] ^ x[i];
                r  = {16'h0, r[14:0], 1'b0} ^ (fb ? {16'h0, POLY_NARROW} : 32'h0);
            end else begin
                fb = r[31] ^ x[i];
                r  = {r[30:0], 1'b0} ^ (fb ? POLY_WIDE : 32'h0);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_fold.sv
module crc_fold
    import crc_eng_pkg::*;
#(
    parameter int NLANES = LANES
) (
    input  logic [31:0]         rem_in,
    input  logic [NLANES*8-1:0] data,
    input  logic [NLANES-1:0]   be,
    input  crc_cfg_t            cfg,
    output logic [31:0]         rem_out
);
    logic [31:0] stage [0:NLANES];

    assign stage[0] = rem_in;

    // Chain of byte stages, most significant lane first.
    generate
        for (genvar g = 0; g < NLANES; g++) begin : g_lane
            localparam int LANE = NLANES - 1 - g;
            assign stage[g+1] = be[LANE] ? fold_byte(stage[g], data[LANE*8 +: 8], cfg)
                                         : stage[g];
        end
    endgenerate

    assign rem_out = stage[NLANES];
endmodule

// File: rtl/crc_shape.sv
module crc_shape
    import crc_eng_pkg::*;
(
    input  logic [31:0] rem,
    input  crc_cfg_t    cfg,
    output logic [31:0] result
);
    logic [31:0] masked;
    logic [31:0] flipped;

    always_comb begin
        masked  = cfg.narrow ? {16'h0, rem[15:0]} : rem;
        flipped = masked;
        if (cfg.refl_out) begin
            flipped = '0;
            if (cfg.narrow) begin
                for (int i = 0; i < 16; i++) flipped[i] = masked[15-i];
            end else begin
                for (int i = 0; i < 32; i++) flipped[i] = masked[31-i];
            end
        end
        if (cfg.invert) result = flipped ^ (cfg.narrow ? 32'h0000FFFF : 32'hFFFFFFFF);
        else            result = flipped;
    end

    always_comb begin
        if (cfg.narrow) assert (result[31:16] == 16'h0) else $error("AST_SHAPE_NARROW"); // R9
    end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_eng_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int CFG_ADDR = 0,
    parameter int DAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int NLANES = LANES;

    crc_state_e  state_q, state_d;
    crc_cfg_t    cfg_q, cfg_new;
    logic [31:0] rem_q, rem_folded, result;
    logic        cfg_wr, dat_wr, any_lane;

    assign cfg_wr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(CFG_ADDR));
    assign dat_wr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(DAT_ADDR));
    assign any_lane = |bus_be;
    assign cfg_new  = crc_cfg_t'(bus_wdata[CFG_W-1:0]);

    crc_fold #(.NLANES(NLANES)) u_fold (
        .rem_in (rem_q),
        .data   (bus_wdata),
        .be     (bus_be),
        .cfg    (cfg_q),
        .rem_out(rem_folded)
    );

    crc_shape u_shape (
        .rem   (rem_q),
        .cfg   (cfg_q),
        .result(result)
    );

    // Next-state logic: T_RELOAD, T_ABSORB, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEDED:  if (cfg_wr) state_d = ST_SEEDED;
                        else if (dat_wr && any_lane) state_d = ST_FOLDING;
            ST_FOLDING: if (cfg_wr) state_d = ST_SEEDED;
            default:    state_d = ST_SEEDED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEEDED;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            rem_q <= 32'hFFFFFFFF;
        end else if (cfg_wr) begin
            cfg_q <= cfg_new;
            rem_q <= seed_for(cfg_new);
        end else if (dat_wr) begin
            rem_q <= rem_folded;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == ADDR_W'(CFG_ADDR))      bus_rdata = {{(32-CFG_W){1'b0}}, cfg_q};
            else if (bus_addr == ADDR_W'(DAT_ADDR)) bus_rdata = result;
        end
    end

    AST_SEEDED_MATCHES_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SEEDED |-> rem_q == seed_for(cfg_q)) else $error("seed mismatch"); // R3
    AST_RELOAD_ENTERS_SEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> state_q == ST_SEEDED) else $error("reload"); // R3
    AST_EMPTY_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !any_lane) |=> $stable(rem_q)) else $error("empty write"); // R5
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr || dat_wr) |=> ($stable(rem_q) && $stable(cfg_q))) else $error("quiet"); // R5
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.narrow |-> rem_q[31:16] == 16'h0) else $error("narrow upper"); // R2
    AST_ABSORB_LEAVES_SEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && any_lane) |=> state_q == ST_FOLDING) else $error("absorb"); // R4
endmodule

// File: tb/crc_engine_bench.sv
`timescale 1ns/1ps
module crc_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    crc_engine u_crc_engine (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // {configuration, expected result for "123456789"}
    localparam logic [36:0] VEC [8] = '{
        {5'b01110, 32'hCBF43926},   // R1 R6 R7 R8
        {5'b00000, 32'h0376E6E7},   // R1
        {5'b01000, 32'hFC891918},   // R1 R8
        {5'b00110, 32'h340BC6D9},   // R1 R6 R7
        {5'b00001, 32'h000029B1},   // R2 R9
        {5'b01111, 32'h0000906E},   // R2 R6 R7 R8
        {5'b10001, 32'h000031C3},   // R2 R3
        {5'b10111, 32'h00002189}    // R2 R3 R6 R7
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = '0; bus_wdata = '0;
        #1 v = bus_rdata;
    endtask

    task automatic feed_check_string();
        wr(2'd1, 4'b1111, 32'h31323334);
        wr(2'd1, 4'b1111, 32'h35363738);
        wr(2'd1, 4'b1000, 32'h39000000);
    endtask

    initial begin
        logic [31:0] v, a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        rd(2'd0, v); check("R10 reset config", v, 32'h0);
        rd(2'd1, v); check("R10 reset result", v, 32'hFFFFFFFF);

        // R9: no strobe gives zero
        @(negedge clk); bus_sel = 1'b0; bus_addr = 2'd1; #1 v = bus_rdata;
        check("R9 idle rdata", v, 32'h0);

        // Vector table: standard check values, back-to-back writes (R4)
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, 4'b1111, {27'h0, VEC[i][36:32]});
            feed_check_string();
            rd(2'd1, v); check($sformatf("R1/R2/R4 vector %0d", i), v, VEC[i][31:0]);
            rd(2'd0, v); check($sformatf("R9 config readback %0d", i), v, {27'h0, VEC[i][36:32]});
        end

        // R5: empty write and unused address change nothing
        wr(2'd0, 4'b1111, 32'h0);
        wr(2'd1, 4'b1111, 32'h31323334);
        rd(2'd1, a);
        wr(2'd1, 4'b0000, 32'hDEADBEEF);
        rd(2'd1, v); check("R5 empty write", v, a);
        wr(2'd2, 4'b1111, 32'h0000001F);
        rd(2'd1, v); check("R5 unused address result", v, a);
        rd(2'd0, v); check("R5 unused address config", v, 32'h0);

        // R4: one lane at a time equals a full word
        wr(2'd0, 4'b1111, 32'h0);
        wr(2'd1, 4'b1000, 32'h31AAAAAA);
        wr(2'd1, 4'b0100, 32'hAA32AAAA);
        wr(2'd1, 4'b0010, 32'hAAAA33AA);
        wr(2'd1, 4'b0001, 32'hAAAAAA34);
        rd(2'd1, v); check("R4 lane split", v, a);

        // R5: sparse enables skip lanes
        wr(2'd0, 4'b1111, 32'h0);
        wr(2'd1, 4'b1100, 32'h3132AAAA);
        rd(2'd1, b);
        wr(2'd0, 4'b1111, 32'h0);
        wr(2'd1, 4'b1010, 32'h31553266);
        rd(2'd1, v); check("R5 sparse lanes", v, b);

        // R6: reflected input differs from plain input on same data
        wr(2'd0, 4'b1111, 32'h00000002);
        wr(2'd1, 4'b1111, 32'h31323334);
        rd(2'd1, v);
        n_checks++;
        if (v === a) begin
            n_errors++;
            $display("FAIL R6 input order ignored actual=%08h expected!=%08h", v, a);
        end

        // R3: reload discards partial state; seed selections and shaping
        wr(2'd0, 4'b1111, 32'h00000000);
        rd(2'd1, v); check("R3 reload wide", v, 32'hFFFFFFFF);
        wr(2'd0, 4'b1111, 32'h00000010);
        rd(2'd1, v); check("R3 zero seed", v, 32'h0);
        wr(2'd0, 4'b1111, 32'h00000001);
        rd(2'd1, v); check("R3 narrow seed", v, 32'h0000FFFF);
        wr(2'd0, 4'b1111, 32'h00000009);
        rd(2'd1, v); check("R8 narrow invert seed", v, 32'h0);
        wr(2'd0, 4'b1111, 32'h00000018);
        rd(2'd1, v); check("R8 wide invert zero seed", v, 32'hFFFFFFFF);
        wr(2'd0, 4'b1111, 32'hFFFFFF61);
        rd(2'd0, v); check("R9 config masked", v, 32'h00000001);

        // R7: reverse a known narrow result (0x29B1 -> 0x8D94)
        wr(2'd0, 4'b1111, 32'h00000005);
        feed_check_string();
        rd(2'd1, v); check("R7 narrow reverse", v, 32'h00008D94);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule